// File: doc/BRIEF.md
# Pass-Voltage Tuning Controller

This controller finds, for one storage block at a time, the lowest pass-through voltage code whose induced read errors the error-correction decoder can still absorb. It is given a block index and a start pulse, typically raised once per block by a daily scheduling tick. It then issues trial reads through a valid/ready handshake. For each trial it waits for the decoder's corrected-error count and uncorrectable flag before picking the next code. The decoder's correction limit is an input that stays steady while a search runs.

The search has three phases. The first trial runs at the nominal (maximum) code. It measures the spare correction margin, which is the limit minus the errors seen. The code then falls in coarse steps until a trial overflows the decoder, or until the floor is reached. After that it rises one LSB at a time until the errors fall strictly below the limit. The code reached that way is reported with a done pulse and stored in a per-block table. During normal reads, an uncorrectable result on a block produces a retry code one coarse step above that block's stored code. Useful codes lie within a few percent of nominal, so the range between floor and maximum is narrow.

Top module: `vpt_ctrl`

## Requirements
- R1: After reset, trial_valid, busy, done and retry_valid are 0, vcode is CODE_MAX (255 by default), and every table entry reads CODE_MAX.
- R2: The first trial of a search is issued at CODE_MAX. When that trial is neither uncorrectable nor above the limit, est_margin becomes ecc_limit minus res_err. Otherwise est_margin keeps its previous value.
- R3: If the first trial is uncorrectable or has res_err greater than ecc_limit, the search ends at once with code CODE_MAX.
- R4: While descending, each trial that neither is uncorrectable nor exceeds the limit lowers the next trial code by COARSE_STEP (4 by default). The code saturates at CODE_FLOOR (240 by default).
- R5: The first descending trial that is uncorrectable or exceeds the limit ends the descent. The next trial is issued at that code plus 1.
- R6: While ascending, the search ends at the first trial that is correctable with res_err strictly below ecc_limit, and reports that code. Otherwise the next trial is 1 higher, up to CODE_MAX, where the search ends.
- R7: A correctable trial at CODE_FLOOR during descent ends the search at the floor if res_err is below the limit. If res_err equals the limit, the search goes to ascent at floor plus 1.
- R8: vcode always lies within CODE_FLOOR to CODE_MAX inclusive.
- R9: trial_valid is held with vcode unchanged until trial_ready is sampled high. No new trial is requested until res_valid returns the result.
- R10: A finished search gives a one-cycle done pulse with done_code. The table entry for the searched block holds that code from the same cycle. All other entries are unchanged.
- R11: tune_start while busy is ignored: the running search and its target block are unaffected.
- R12: rd_uncorr with rd_blk gives, one cycle later, retry_valid with retry_code equal to the stored code of rd_blk plus COARSE_STEP, saturated at CODE_MAX. A table write to the same block in the same cycle is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tune_start | input | 1 | Start pulse for a search |
| tune_blk | input | BLK_W | Block to tune |
| ecc_limit | input | ERR_W | Decoder correction limit |
| trial_valid | output | 1 | Trial read request |
| trial_ready | input | 1 | Trial request accepted |
| vcode | output | CODE_W | Pass-voltage code for the array driver |
| res_valid | input | 1 | Trial result strobe |
| res_err | input | ERR_W | Corrected-error count of the trial |
| res_uncorr | input | 1 | Trial was uncorrectable |
| est_margin | output | ERR_W | Spare margin from the first trial |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished (one cycle) |
| done_code | output | CODE_W | Tuned code |
| rd_uncorr | input | 1 | Normal read at the stored code failed |
| rd_blk | input | BLK_W | Block of the failed normal read |
| retry_valid | output | 1 | Retry code valid |
| retry_code | output | CODE_W | Raised code for the reissued read |
| tbl_rd_blk | input | BLK_W | Table lookup index |
| tbl_rd_code | output | CODE_W | Stored code of tbl_rd_blk |

## Verification
Two functions can meet in one cycle: the table write of a finishing search, and the retry lookup triggered by a failed normal read of that same block. The bench provokes this by raising rd_uncorr for the block being tuned in the exact cycle it returns the last trial result. The stale stored code would give a different retry code than the freshly tuned one. A correct retry_code therefore shows that the write is forwarded, and not read a cycle late.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} vpt_state_e;
  typedef enum logic [1:0] {PH_EST, PH_DESC, PH_ASC} vpt_phase_e;

  // coarse move toward the floor, never below it
  function automatic int unsigned vpt_down(int unsigned c, int unsigned s, int unsigned fl);
    return (c >= fl + s) ? c - s : fl;
  endfunction

  // move up by s, never above the top code
  function automatic int unsigned vpt_up(int unsigned c, int unsigned s, int unsigned mx);
    return (c + s >= mx) ? mx : c + s;
  endfunction

  // decoder overflowed: uncorrectable or above its limit
  function automatic logic vpt_exceeds(int unsigned e, int unsigned lim, logic unc);
    return unc || (e > lim);
  endfunction

  // decoder absorbed with room: strictly below the limit
  function automatic logic vpt_absorbs(int unsigned e, int unsigned lim, logic unc);
    return !unc && (e < lim);
  endfunction

endpackage

// File: rtl/vpt_table.sv
module vpt_table #(
  parameter int BLK_W    = 4,
  parameter int CODE_W   = 8,
  parameter int CODE_MAX = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BLK_W-1:0]  wa,
  input  logic [CODE_W-1:0] wd,
  input  logic [BLK_W-1:0]  ra_look,
  output logic [CODE_W-1:0] rd_look,
  input  logic [BLK_W-1:0]  ra_fwd,
  output logic [CODE_W-1:0] rd_fwd
);
  localparam int NBLK = 1 << BLK_W;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(CODE_MAX);

  logic [CODE_W-1:0] ent [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ent[g] <= RST_CODE;
      else if (we && wa == BLK_W'(g))     ent[g] <= wd;
    end
  end

  assign rd_look = ent[ra_look];
  // same-cycle write to the looked-up block wins
  assign rd_fwd  = (we && wa == ra_fwd) ? wd : ent[ra_fwd];
endmodule

// File: rtl/vpt_search.sv
module vpt_search
  import vpt_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int CODE_W      = 8,
  parameter int ERR_W       = 8,
  parameter int CODE_MAX    = 255,
  parameter int CODE_FLOOR  = 240,
  parameter int COARSE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk,
  input  logic [ERR_W-1:0]  limit,
  input  logic              trial_ready,
  input  logic              res_valid,
  input  logic [ERR_W-1:0]  res_err,
  input  logic              res_uncorr,
  output logic              trial_valid,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic [ERR_W-1:0]  margin,
  output logic              we,
  output logic [BLK_W-1:0]  wa,
  output logic [CODE_W-1:0] wd,
  output logic [BLK_W-1:0]  cur_blk,
  output logic              coarse_ev,
  output logic              fine_ev
);
  localparam logic [CODE_W-1:0] TOP_C = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] FLR_C = CODE_W'(CODE_FLOOR);

  vpt_state_e st;
  vpt_phase_e ph;

  logic              take;
  logic              over, under;
  logic              fin;
  logic [CODE_W-1:0] fin_code, nxt_code, down_c, up_c;
  vpt_phase_e        nxt_ph;

  assign take   = (st == ST_WAIT) && res_valid;
  assign over   = vpt_exceeds(32'(res_err), 32'(limit), res_uncorr);
  assign under  = vpt_absorbs(32'(res_err), 32'(limit), res_uncorr);
  assign down_c = CODE_W'(vpt_down(32'(code), COARSE_STEP, CODE_FLOOR));
  assign up_c   = CODE_W'(vpt_up(32'(code), 1, CODE_MAX));

  always_comb begin
    fin       = 1'b0;
    fin_code  = code;
    nxt_code  = code;
    nxt_ph    = ph;
    coarse_ev = 1'b0;
    fine_ev   = 1'b0;
    if (take) begin
      unique case (ph)
        PH_EST: begin
          if (over) begin
            fin = 1'b1; fin_code = TOP_C;
          end else if (code <= FLR_C) begin
            fin = 1'b1; fin_code = code;
          end else begin
            nxt_code = down_c; nxt_ph = PH_DESC; coarse_ev = 1'b1;
          end
        end
        PH_DESC: begin
          if (over || (code == FLR_C && !under)) begin
            if (code == TOP_C) begin
              fin = 1'b1; fin_code = TOP_C;
            end else begin
              nxt_code = up_c; nxt_ph = PH_ASC; fine_ev = 1'b1;
            end
          end else if (code == FLR_C) begin
            fin = 1'b1; fin_code = code;
          end else begin
            nxt_code = down_c; coarse_ev = 1'b1;
          end
        end
        default: begin
          if (under) begin
            fin = 1'b1; fin_code = code;
          end else if (code == TOP_C) begin
            fin = 1'b1; fin_code = TOP_C;
          end else begin
            nxt_code = up_c; fine_ev = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_EST;
      code      <= TOP_C;
      cur_blk   <= '0;
      done      <= 1'b0;
      done_code <= TOP_C;
      margin    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          cur_blk <= blk;
          code    <= TOP_C;
          ph      <= PH_EST;
          st      <= ST_REQ;
        end
        ST_REQ: if (trial_ready) st <= ST_WAIT;
        default: if (take) begin
          if (ph == PH_EST && !over) margin <= limit - res_err;
          if (fin) begin
            done      <= 1'b1;
            done_code <= fin_code;
            code      <= fin_code;
            st        <= ST_IDLE;
          end else begin
            code <= nxt_code;
            ph   <= nxt_ph;
            st   <= ST_REQ;
          end
        end
      endcase
    end
  end

  assign trial_valid = (st == ST_REQ);
  assign busy        = (st != ST_IDLE);
  assign we          = fin;
  assign wa          = cur_blk;
  assign wd          = fin_code;
endmodule

// File: rtl/vpt_retry.sv
module vpt_retry
  import vpt_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CODE_MAX    = 255,
  parameter int COARSE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_in,
  input  logic [CODE_W-1:0] base_code,
  output logic              retry_valid,
  output logic [CODE_W-1:0] retry_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_valid <= 1'b0;
      retry_code  <= CODE_W'(CODE_MAX);
    end else begin
      retry_valid <= fail_in;
      if (fail_in)
        retry_code <= CODE_W'(vpt_up(32'(base_code), COARSE_STEP, CODE_MAX));
    end
  end
endmodule

// File: rtl/vpt_ctrl.sv
module vpt_ctrl #(
  parameter int BLK_W       = 4,
  parameter int CODE_W      = 8,
  parameter int ERR_W       = 8,
  parameter int CODE_MAX    = 255,
  parameter int CODE_FLOOR  = 240,
  parameter int COARSE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tune_start,
  input  logic [BLK_W-1:0]  tune_blk,
  input  logic [ERR_W-1:0]  ecc_limit,
  output logic              trial_valid,
  input  logic              trial_ready,
  output logic [CODE_W-1:0] vcode,
  input  logic              res_valid,
  input  logic [ERR_W-1:0]  res_err,
  input  logic              res_uncorr,
  output logic [ERR_W-1:0]  est_margin,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  input  logic              rd_uncorr,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic              retry_valid,
  output logic [CODE_W-1:0] retry_code,
  input  logic [BLK_W-1:0]  tbl_rd_blk,
  output logic [CODE_W-1:0] tbl_rd_code
);
  // named internal events, visible to the bound checker
  logic              tbl_we;
  logic [BLK_W-1:0]  tbl_wa;
  logic [CODE_W-1:0] tbl_wd;
  logic [BLK_W-1:0]  cur_blk;
  logic              coarse_ev, fine_ev;
  logic [CODE_W-1:0] fwd_code;

  vpt_search #(
    .BLK_W(BLK_W), .CODE_W(CODE_W), .ERR_W(ERR_W), .CODE_MAX(CODE_MAX),
    .CODE_FLOOR(CODE_FLOOR), .COARSE_STEP(COARSE_STEP)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .start(tune_start), .blk(tune_blk),
    .limit(ecc_limit), .trial_ready(trial_ready), .res_valid(res_valid),
    .res_err(res_err), .res_uncorr(res_uncorr), .trial_valid(trial_valid),
    .code(vcode), .busy(busy), .done(done), .done_code(done_code),
    .margin(est_margin), .we(tbl_we), .wa(tbl_wa), .wd(tbl_wd),
    .cur_blk(cur_blk), .coarse_ev(coarse_ev), .fine_ev(fine_ev)
  );

  vpt_table #(
    .BLK_W(BLK_W), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wa(tbl_wa), .wd(tbl_wd),
    .ra_look(tbl_rd_blk), .rd_look(tbl_rd_code),
    .ra_fwd(rd_blk), .rd_fwd(fwd_code)
  );

  vpt_retry #(
    .CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .COARSE_STEP(COARSE_STEP)
  ) u_retry (
    .clk(clk), .rst_n(rst_n), .fail_in(rd_uncorr), .base_code(fwd_code),
    .retry_valid(retry_valid), .retry_code(retry_code)
  );
endmodule

// File: rtl/vpt_ctrl_chk.sv
module vpt_ctrl_chk #(
  parameter int BLK_W       = 4,
  parameter int CODE_W      = 8,
  parameter int CODE_MAX    = 255,
  parameter int CODE_FLOOR  = 240,
  parameter int COARSE_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tune_start,
  input logic              trial_valid,
  input logic              trial_ready,
  input logic [CODE_W-1:0] vcode,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] done_code,
  input logic              rd_uncorr,
  input logic              retry_valid,
  input logic              tbl_we,
  input logic [CODE_W-1:0] tbl_wd,
  input logic [BLK_W-1:0]  cur_blk,
  input logic              coarse_ev,
  input logic              fine_ev
);
  localparam logic [CODE_W-1:0] TOP_C  = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] FLR_C  = CODE_W'(CODE_FLOOR);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(COARSE_STEP);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !trial_valid);

  assert_first_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> vcode == TOP_C);

  assert_coarse_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_ev |=> (vcode < $past(vcode)) && (($past(vcode) - vcode) <= STEP_C));

  assert_fine_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fine_ev |=> vcode == $past(vcode) + 1'b1);

  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vcode >= FLR_C && vcode <= TOP_C);

  assert_trial_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trial_valid && !trial_ready |=> trial_valid && $stable(vcode));

  assert_done_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> done && done_code == $past(tbl_wd));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tune_start |=> $stable(cur_blk));

  assert_retry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uncorr |=> retry_valid);
endmodule

bind vpt_ctrl vpt_ctrl_chk #(
  .BLK_W(BLK_W), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX),
  .CODE_FLOOR(CODE_FLOOR), .COARSE_STEP(COARSE_STEP)
) i_chk (
  .clk(clk), .rst_n(rst_n), .tune_start(tune_start), .trial_valid(trial_valid),
  .trial_ready(trial_ready), .vcode(vcode), .busy(busy), .done(done),
  .done_code(done_code), .rd_uncorr(rd_uncorr), .retry_valid(retry_valid),
  .tbl_we(tbl_we), .tbl_wd(tbl_wd), .cur_blk(cur_blk),
  .coarse_ev(coarse_ev), .fine_ev(fine_ev)
);

// File: tb/test_vpt_ctrl.sv
module test_vpt_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tune_start = 1'b0;
  logic [3:0] tune_blk = '0;
  logic [7:0] ecc_limit = '0;
  logic       trial_valid;
  logic       trial_ready = 1'b0;
  logic [7:0] vcode;
  logic       res_valid = 1'b0;
  logic [7:0] res_err = '0;
  logic       res_uncorr = 1'b0;
  logic [7:0] est_margin;
  logic       busy, done;
  logic [7:0] done_code;
  logic       rd_uncorr = 1'b0;
  logic [3:0] rd_blk = '0;
  logic       retry_valid;
  logic [7:0] retry_code;
  logic [3:0] tbl_rd_blk = '0;
  logic [7:0] tbl_rd_code;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  vpt_ctrl i_vpt_ctrl (.*);

  // {collide, blk, limit, slope, base, expected code, expected margin}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'd3,  8'd20, 8'd3,  8'd2, 8'd250, 8'd18},  // ascent passes equal-limit
    {1'b1, 4'd5,  8'd10, 8'd1,  8'd0, 8'd246, 8'd10},  // collides with retry
    {1'b0, 4'd0,  8'd50, 8'd1,  8'd0, 8'd240, 8'd50},  // reaches floor
    {1'b0, 4'd7,  8'd5,  8'd1,  8'd6, 8'd255, 8'd50},  // estimate fails, margin held
    {1'b0, 4'd9,  8'd15, 8'd1,  8'd0, 8'd241, 8'd15},  // floor at limit
    {1'b0, 4'd12, 8'd20, 8'd10, 8'd0, 8'd254, 8'd20}   // uncorrectable trials
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat_up(int c, int s);
    return (c + s > 255) ? 255 : c + s;
  endfunction

  task automatic run_vec(input int idx);
    logic [44:0] v;
    logic col;
    int blk, lim, slope, base, expc, expm, c, e, ntr;
    bit first, fin;
    v = VEC[idx];
    {col} = v[44];
    blk = int'(v[43:40]); lim = int'(v[39:32]); slope = int'(v[31:24]);
    base = int'(v[23:16]); expc = int'(v[15:8]); expm = int'(v[7:0]);
    ecc_limit = 8'(lim);
    @(posedge clk); #1 tune_start = 1'b1; tune_blk = 4'(blk);
    @(posedge clk); #1 tune_start = 1'b0;
    @(negedge clk);
    first = 1'b1; fin = 1'b0; ntr = 0;
    while (!fin && ntr < 40) begin
      check(trial_valid == 1'b1, "R9 trial requested", int'(trial_valid), 1);
      c = int'(vcode);
      if (first) check(c == 255, "R2 first trial at top", c, 255);
      check(c >= 240 && c <= 255, "R8 code in range", c, 240);
      @(negedge clk);
      check(trial_valid && int'(vcode) == c, "R9 held while not ready", int'(vcode), c);
      @(posedge clk); #1 trial_ready = 1'b1;
      if (first) begin tune_start = 1'b1; tune_blk = 4'd14; end  // R11
      @(posedge clk); #1 trial_ready = 1'b0; tune_start = 1'b0;
      @(negedge clk);
      check(!trial_valid, "R9 no request while awaiting result", int'(trial_valid), 0);
      @(posedge clk); #1;
      e = base + slope * (255 - c);
      res_valid = 1'b1; res_err = 8'(e); res_uncorr = (e > lim + 8);
      if (col && c == expc) begin rd_uncorr = 1'b1; rd_blk = 4'(blk); end
      @(posedge clk); #1 res_valid = 1'b0; rd_uncorr = 1'b0; res_uncorr = 1'b0;
      @(negedge clk);
      if (done) begin
        fin = 1'b1;
        check(int'(done_code) == expc, "R3/R5/R6/R7 tuned code", int'(done_code), expc);
        tbl_rd_blk = 4'(blk); #0.1;
        check(int'(tbl_rd_code) == expc, "R10 table written with done", int'(tbl_rd_code), expc);
        if (col) begin
          check(retry_valid == 1'b1, "R12 retry on collision", int'(retry_valid), 1);
          check(int'(retry_code) == sat_up(expc, 4), "R12 forwarded retry code",
                int'(retry_code), sat_up(expc, 4));
        end
      end
      first = 1'b0; ntr++;
    end
    check(fin, "R6 search finished", ntr, 0);
    check(int'(est_margin) == expm, "R2 estimated margin", int'(est_margin), expm);
    @(negedge clk);
    check(!done && !busy, "R10 done is a single pulse", int'(done), 0);
    tbl_rd_blk = 4'd14; #0.1;
    check(int'(tbl_rd_code) == 255, "R11 start during search ignored", int'(tbl_rd_code), 255);
  endtask

  task automatic retry_probe(input int blk, input int exp);
    @(posedge clk); #1 rd_uncorr = 1'b1; rd_blk = 4'(blk);
    @(posedge clk); #1 rd_uncorr = 1'b0;
    @(negedge clk);
    check(retry_valid && int'(retry_code) == exp, "R12 retry code", int'(retry_code), exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    int codes [16];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!trial_valid && !busy && !done && !retry_valid, "R1 outputs idle", int'(busy), 0);
    check(vcode == 8'd255, "R1 code at top", int'(vcode), 255);
    for (int b = 0; b < 16; b++) begin
      tbl_rd_blk = 4'(b); #0.1;
      check(tbl_rd_code == 8'd255, "R1 table reset", int'(tbl_rd_code), 255);
      codes[b] = 255;
    end
    for (int i = 0; i < NV; i++) begin
      run_vec(i);
      codes[int'(VEC[i][43:40])] = int'(VEC[i][15:8]);
    end
    // R10 no other entry disturbed
    @(negedge clk);
    for (int b = 0; b < 16; b++) begin
      tbl_rd_blk = 4'(b); #0.1;
      check(int'(tbl_rd_code) == codes[b], "R10 table contents", int'(tbl_rd_code), codes[b]);
    end
    // R12 directed retries, including saturation
    retry_probe(3, 254);
    retry_probe(7, 255);
    retry_probe(0, 244);
    retry_probe(1, 255);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule